// File: doc/BRIEF.md
# UART Oversampling Tick Generator

This block produces the clock-enable tick that paces a UART's transmit and receive shift logic at sixteen times the serial bit rate. It runs from a fixed 24 MHz system clock. A free-running prescaler divides that clock by 13, which gives a base rate near 1.846 MHz. A 16-bit down-counter then divides the base rate by a divisor that software loads as two bytes.

A fast mode skips the prescaler. The counter then advances on every system clock, so the same divisor gives a rate 13 times higher. With a divisor of 1 in fast mode the tick is high on every cycle: 24 MHz / 16, which is 1.5 Mbit/s. A write to either divisor byte makes the counter reload on the next base-rate enable, so a new rate does not wait for the old count to run out. A divisor of zero stops the ticks.

Top module: `baud_tick_gen`

## Requirements
- R1: While rst_ni is low, and after it is released, tick_o is 0 and both divisor bytes read back as 0.
- R2: A write with reg_we_i high stores reg_wdata_i into the low divisor byte when reg_addr_i is 0, or into the high byte when it is 1. reg_rdata_o shows the byte selected by reg_addr_i, with no cycle of delay.
- R3: While the divisor is 0, tick_o stays 0.
- R4: In normal mode, with divisor D held, tick_o pulses once every 13*D system clocks. The prescaler keeps counting through writes and mode changes.
- R5: When mode_i is 2'b11 (fast mode), tick_o pulses once every D system clocks. With D = 1, tick_o is high on every cycle.
- R6: The mode_i codes 2'b00, 2'b01 and 2'b10 all select normal mode.
- R7: After a divisor write, the counter reloads from the new divisor on the next base-rate enable. The old count is dropped, and no tick is issued for that enable.
- R8: Each tick is one system clock wide whenever the period is longer than one cycle. tick_o matches the cycle-exact behaviour on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 24 MHz system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Divisor byte write strobe |
| reg_addr_i | input | 1 | Byte select: 0 = low byte, 1 = high byte |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected byte |
| mode_i | input | 2 | Speed mode; 2'b11 selects fast mode |
| tick_o | output | 1 | 16x oversampling enable, one clock wide |

## Verification
The bench builds the block with its default parameters: a prescale of 13 and a 16-bit divisor made of two bytes. Small divisors keep normal-mode periods at a few dozen cycles, so the bench can measure several periods quickly. A divisor of 258 in fast mode makes the high byte matter. The reference model tracks the prescaler phase on every cycle, so a reload that lands between prescaler wraps is checked against the exact cycle in which it takes effect.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    MODE_STD  = 2'b00,
    MODE_ALT1 = 2'b01,
    MODE_ALT2 = 2'b10,
    MODE_FAST = 2'b11
  } speed_mode_e;
endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int unsigned PRESCALE = 13,
  localparam int unsigned PCW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bypass_i,
  output logic           base_en_o,
  output logic [PCW-1:0] pre_cnt_o
);
  logic [PCW-1:0] pre_q;
  logic           wrap;

  assign wrap = (pre_q == PCW'(PRESCALE - 1));

  // free-running; the phase is kept while bypassed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pre_q <= '0;
    else if (wrap) pre_q <= '0;
    else           pre_q <= pre_q + PCW'(1);
  end

  assign base_en_o = bypass_i | wrap;
  assign pre_cnt_o = pre_q;
endmodule

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned NB = DIV_W / BYTE_W,
  localparam int unsigned AW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              load_o
);
  logic [BYTE_W-1:0] byte_q [NB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NB; i++) byte_q[i] <= '0;
    end else if (we_i) begin
      for (int i = 0; i < NB; i++)
        if (addr_i == AW'(i)) byte_q[i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_pack
    assign div_o[g*BYTE_W +: BYTE_W] = byte_q[g];
  end

  assign rdata_o = byte_q[addr_i];
  assign load_o  = we_i;
endmodule

// File: rtl/baud_down_counter.sv
module baud_down_counter #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             load_i,
  output logic             pend_o,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             pend_q;
  logic             tick_q;
  logic             div_zero;
  logic             at_end;

  assign div_zero = (div_i == '0);
  assign at_end   = (cnt_q <= DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (base_en_i) begin
      if (div_zero)              cnt_q <= '0;
      else if (pend_q || at_end) cnt_q <= div_i;
      else                       cnt_q <= cnt_q - DIV_W'(1);
    end
  end

  // a write arms a reload; the next base enable consumes it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= 1'b0;
    else if (load_i)    pend_q <= 1'b1;
    else if (base_en_i) pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= base_en_i && !div_zero && !pend_q && (cnt_q == DIV_W'(1));
  end

  assign pend_o = pend_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned PRESCALE = 13,
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned BYTE_W   = 8,
  localparam int unsigned NB  = DIV_W / BYTE_W,
  localparam int unsigned AW  = (NB > 1) ? $clog2(NB) : 1,
  localparam int unsigned PCW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  logic [1:0]        mode_i,
  output logic              tick_o
);
  import baud_pkg::*;

  logic             fast_sel;
  logic             base_en;
  logic [PCW-1:0]   pre_cnt;
  logic [DIV_W-1:0] div_val;
  logic             div_load;
  logic             reload_pend;

  assign fast_sel = (speed_mode_e'(mode_i) == MODE_FAST);

  baud_prescale #(.PRESCALE(PRESCALE)) i_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bypass_i  (fast_sel),
    .base_en_o (base_en),
    .pre_cnt_o (pre_cnt)
  );

  baud_div_regs #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .div_o   (div_val),
    .load_o  (div_load)
  );

  baud_down_counter #(.DIV_W(DIV_W)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .base_en_i (base_en),
    .div_i     (div_val),
    .load_i    (div_load),
    .pend_o    (reload_pend),
    .tick_o    (tick_o)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int unsigned PRESCALE = 13,
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned AW       = 1,
  parameter int unsigned PCW      = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fast_i,
  input logic              tick_i,
  input logic              we_i,
  input logic [AW-1:0]     addr_i,
  input logic [BYTE_W-1:0] wdata_i,
  input logic [DIV_W-1:0]  div_i,
  input logic              pend_i,
  input logic [PCW-1:0]    pre_cnt_i
);
  localparam int unsigned NB = DIV_W / BYTE_W;

  // R1: prescaler phase never leaves its range
  p_pre_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_cnt_i < PCW'(PRESCALE));

  // R2: low byte captures write data
  p_wr_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(0)) |=> (div_i[BYTE_W-1:0] == $past(wdata_i)));

  // R2: top byte captures write data
  p_wr_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(NB-1)) |=> (div_i[DIV_W-1:DIV_W-BYTE_W] == $past(wdata_i)));

  // R3: zero divisor yields no tick
  p_zero_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(div_i == '0) |-> !tick_i);

  // R7: a write arms the reload
  p_reload_arm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> pend_i);

  // R8: normal-mode ticks are single cycle
  p_one_wide_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !fast_i && !$past(fast_i)) |=> !tick_i);
endmodule

bind baud_tick_gen baud_tick_gen_chk #(
  .PRESCALE(PRESCALE), .DIV_W(DIV_W), .BYTE_W(BYTE_W), .AW(AW), .PCW(PCW)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fast_i    (fast_sel),
  .tick_i    (tick_o),
  .we_i      (reg_we_i),
  .addr_i    (reg_addr_i),
  .wdata_i   (reg_wdata_i),
  .div_i     (div_val),
  .pend_i    (reload_pend),
  .pre_cnt_i (pre_cnt)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic       reg_addr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [1:0] mode_i = 2'b00;
  logic       tick_o;

  always #4 clk_i = ~clk_i;

  baud_tick_gen i_baud_tick_gen (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .mode_i, .tick_o
  );

  int    n_run = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    done = 0;
  string cur_req = "R1";

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_pre = 0, m_cnt = 0, m_div = 0;
  bit m_pend = 0, m_tick = 0;
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_pre = 0; m_cnt = 0; m_div = 0; m_pend = 0; m_tick = 0;
    end else begin
      bit be, nt;
      be = (mode_i == 2'b11) || (m_pre == 12);
      nt = be && (m_div != 0) && !m_pend && (m_cnt == 1);
      if (be) begin
        if (m_div == 0) m_cnt = 0;
        else if (m_pend || m_cnt <= 1) m_cnt = m_div;
        else m_cnt = m_cnt - 1;
        m_pend = 0;
      end
      m_pre = (m_pre == 12) ? 0 : m_pre + 1;
      if (reg_we_i) begin
        if (reg_addr_i) m_div = (m_div & 32'h00ff) | (int'(reg_wdata_i) << 8);
        else            m_div = (m_div & 32'hff00) | int'(reg_wdata_i);
        m_pend = 1;
      end
      m_tick = nt;
    end
  end

  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni && !done) chk({cur_req, " model"}, int'(tick_o), int'(m_tick));
  end

  task automatic wr(bit a, int d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d[7:0];
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic wait_tick(output int t);
    t = -1;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk_i);
      if (tick_o) begin t = cyc; break; end
    end
  endtask

  task automatic period(string req, int exp);
    int t1, t2;
    wait_tick(t1);
    wait_tick(t2);
    chk({req, " period"}, t2 - t1, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int t, cnt;
    repeat (3) @(negedge clk_i);
    chk("R1 tick in reset", int'(tick_o), 0);
    chk("R1 low in reset", int'(reg_rdata_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    reg_addr_i = 1'b1; #1;
    chk("R1 high after reset", int'(reg_rdata_o), 0);

    cur_req = "R3";
    cnt = 0;
    for (int k = 0; k < 100; k++) begin @(negedge clk_i); cnt += int'(tick_o); end
    chk("R3 no ticks at zero", cnt, 0);

    cur_req = "R2";
    wr(0, 3);
    reg_addr_i = 1'b0; #1;
    chk("R2 low readback", int'(reg_rdata_o), 3);
    reg_addr_i = 1'b1; #1;
    chk("R2 high readback", int'(reg_rdata_o), 0);

    cur_req = "R4"; mode_i = 2'b00;
    period("R4", 39);
    // R8: the cycle after a tick is low in normal mode
    @(negedge clk_i);
    chk("R8 width", int'(tick_o), 0);
    cur_req = "R6"; mode_i = 2'b01;
    period("R6 mode 01", 39);
    mode_i = 2'b10;
    period("R6 mode 10", 39);

    cur_req = "R5"; mode_i = 2'b11;
    period("R5 fast", 3);
    wr(0, 1);
    period("R5 fast div1", 1);
    cnt = 0;
    for (int k = 0; k < 10; k++) begin @(negedge clk_i); cnt += int'(tick_o); end
    chk("R5 continuous", cnt, 10);

    cur_req = "R2";
    wr(1, 1); wr(0, 2);
    reg_addr_i = 1'b1; #1;
    chk("R2 high byte", int'(reg_rdata_o), 1);
    period("R2 fast 258", 258);

    cur_req = "R7"; mode_i = 2'b00;
    wr(1, 0); wr(0, 200);
    wait_tick(t);
    repeat (5) @(negedge clk_i);
    wr(0, 2);
    t = cyc;
    wait_tick(cnt);
    chk("R7 early reload", int'(cnt - t <= 40 && cnt > t), 1);
    period("R7 new rate", 26);

    cur_req = "R3";
    wr(0, 0);
    repeat (2) @(negedge clk_i);
    cnt = 0;
    for (int k = 0; k < 200; k++) begin @(negedge clk_i); cnt += int'(tick_o); end
    chk("R3 stop on zero", cnt, 0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule